// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a single register stage placed between a memory controller and the DRAM devices on a registered memory module. It captures the command and address bits on the rising clock edge and repeats them to the devices. A static width-mode input chooses how the captured bits reach the outputs. In wide mode, 25 bits each drive one output. In duplicated mode, 14 bits each drive two outputs. A second static input picks one of two output arrangements for duplicated mode.

Two active-low chip-select inputs act together as a freeze. When both are high at a clock edge, the outputs keep their values. The active-low reset is asynchronous. It clears the register and forces every output low at once, and it overrides the freeze. Reset release passes through an internal synchroniser, so the first capture after release always happens cleanly on a clock edge and the outputs cannot glitch.

Top module: `cmd_repeat_reg`

## Requirements
- R1: With `dup_mode` low, `cmd_q[i]` equals `cmd_d[i]` as captured for i in 0..24, and `cmd_q[27:25]` is 0.
- R2: With `dup_mode` high and `alt_map` low, `cmd_q[i]` and `cmd_q[i+14]` both equal captured `cmd_d[i]` for i in 0..13. `cmd_d[24:14]` has no effect on the outputs.
- R3: With `dup_mode` high and `alt_map` high, `cmd_q[i]` equals captured `cmd_d[i]` and `cmd_q[27-i]` equals captured `cmd_d[i]` for i in 0..13. The second copy is therefore bit-reversed.
- R4: Outputs change only after a rising clock edge. Input changes between edges do not reach `cmd_q`.
- R5: When `cs_dev_n` and `cs_rank_n` are both high at a rising edge, `cmd_q` keeps its previous value.
- R6: When either chip select is low at a rising edge, the data present at that edge reaches `cmd_q` after that edge.
- R7: While `rst_n` is low, `cmd_q` is 0 immediately, whether or not the clock is running.
- R8: After `rst_n` rises, the first two rising edges capture nothing and `cmd_q` stays 0. The third edge is the first capture.
- R9: Asserting reset while the outputs are frozen by the chip selects still drives `cmd_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dup_mode | input | 1 | 0: 25-bit single copy, 1: 14-bit duplicated |
| alt_map | input | 1 | Duplicated-mode arrangement, 0: A, 1: B (reversed copy) |
| cs_dev_n | input | 1 | Chip select one, active low |
| cs_rank_n | input | 1 | Chip select two, active low |
| cmd_d | input | 25 | Command/address input bits |
| cmd_q | output | 28 | Registered, fanned-out command/address bits |

## Verification
A wrong stored word or a missed enable shows at `cmd_q` one clock after the faulty edge. In duplicated mode the error appears on two pins at once, and in arrangement B it appears at mirrored positions, so a routing mistake separates cleanly from a capture mistake. A wrong reset synchroniser depth shows as output activity on the first or second edge after release, or as a capture missing from the third edge. A freeze decoded from the wrong chip-select combination shows as an output that moves when it should hold, or holds when it should move, on the very next sample.

// File: rtl/crb_pkg.sv
package crb_pkg;

  typedef enum logic [1:0] {
    MAP_WIDE  = 2'd0,
    MAP_DUP_A = 2'd1,
    MAP_DUP_B = 2'd2
  } map_e;

  function automatic map_e decode_map(input logic dup, input logic alt);
    if (!dup)      return MAP_WIDE;
    else if (!alt) return MAP_DUP_A;
    else           return MAP_DUP_B;
  endfunction

  function automatic logic freeze_req(input logic cs_a_n, input logic cs_b_n);
    return cs_a_n & cs_b_n;
  endfunction

endpackage

// File: rtl/crb_rst_sync.sv
module crb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_ok
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= 1'b1;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign run_ok = chain[STAGES-1];
endmodule

// File: rtl/crb_capture.sv
module crb_capture #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
endmodule

// File: rtl/crb_fanout.sv
module crb_fanout
  import crb_pkg::*;
#(
  parameter int IN_W  = 25,
  parameter int DUP_W = 14,
  parameter int OUT_W = 28
) (
  input  map_e             sel,
  input  logic [IN_W-1:0]  word,
  output logic [OUT_W-1:0] pins
);
  always_comb begin
    pins = '0;
    unique case (sel)
      MAP_WIDE: begin
        for (int i = 0; i < IN_W; i++) pins[i] = word[i];
      end
      MAP_DUP_A: begin
        for (int i = 0; i < DUP_W; i++) begin
          pins[i]         = word[i];
          pins[i + DUP_W] = word[i];
        end
      end
      MAP_DUP_B: begin
        for (int i = 0; i < DUP_W; i++) begin
          pins[i]                 = word[i];
          pins[2*DUP_W - 1 - i]   = word[i];
        end
      end
      default: pins = '0;
    endcase
  end
endmodule

// File: rtl/cmd_repeat_reg.sv
module cmd_repeat_reg
  import crb_pkg::*;
#(
  parameter int IN_W     = 25,
  parameter int DUP_W    = 14,
  parameter int SYNC_LEN = 2,
  localparam int OUT_W   = (IN_W > 2*DUP_W) ? IN_W : 2*DUP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dup_mode,
  input  logic             alt_map,
  input  logic             cs_dev_n,
  input  logic             cs_rank_n,
  input  logic [IN_W-1:0]  cmd_d,
  output logic [OUT_W-1:0] cmd_q
);
  // named internal events for the assertions
  logic            run_ok;
  logic            freeze;
  logic            cap_en;
  logic [IN_W-1:0] held_word;
  map_e            route;

  assign freeze = freeze_req(cs_dev_n, cs_rank_n);
  assign cap_en = run_ok & ~freeze;
  assign route  = decode_map(dup_mode, alt_map);

  crb_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_ok (run_ok)
  );

  crb_capture #(.W(IN_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cap_en),
    .din   (cmd_d),
    .dout  (held_word)
  );

  crb_fanout #(.IN_W(IN_W), .DUP_W(DUP_W), .OUT_W(OUT_W)) u_fan (
    .sel  (route),
    .word (held_word),
    .pins (cmd_q)
  );

  generate
    if (OUT_W > IN_W) begin : g_spare_chk
      AST_WIDE_SPARE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_mode |-> cmd_q[OUT_W-1:IN_W] == '0); // R1
    end
  endgenerate

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && freeze) |=> $stable(cmd_q)); // R5

  AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> held_word == $past(cmd_d)); // R6

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |-> cmd_q == '0); // R8

endmodule

// File: tb/cmd_repeat_reg_tb.sv
module cmd_repeat_reg_tb;
  localparam int IN_W  = 25;
  localparam int DUP_W = 14;
  localparam int OUT_W = 28;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dup_mode = 1'b0;
  logic             alt_map = 1'b0;
  logic             cs_dev_n = 1'b1;
  logic             cs_rank_n = 1'b1;
  logic [IN_W-1:0]  cmd_d = '0;
  logic [OUT_W-1:0] cmd_q;

  int total = 0;
  int bad = 0;
  logic [IN_W-1:0]  model_word = '0;
  logic [OUT_W-1:0] last_seen = '0;
  logic [OUT_W-1:0] exp_q[$];
  string            tag_q[$];

  always #5 clk = ~clk;

  cmd_repeat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .dup_mode(dup_mode), .alt_map(alt_map),
    .cs_dev_n(cs_dev_n), .cs_rank_n(cs_rank_n), .cmd_d(cmd_d), .cmd_q(cmd_q)
  );

  function automatic logic [OUT_W-1:0] image(input logic dup, input logic alt,
                                              input logic [IN_W-1:0] w);
    logic [DUP_W-1:0] lo;
    logic [DUP_W-1:0] rev;
    lo  = w[DUP_W-1:0];
    rev = {<<{lo}};
    if (!dup)      return {3'b000, w};
    else if (!alt) return {lo, lo};
    else           return {rev, lo};
  endfunction

  task automatic check(input string tag, input logic [OUT_W-1:0] act,
                       input logic [OUT_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations one per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [OUT_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, cmd_q, e);
      last_seen = cmd_q;
    end
  end

  // driver: one capture edge per call
  task automatic step(input logic [IN_W-1:0] d, input logic c0, input logic c1,
                      input string tag);
    @(negedge clk);
    cmd_d = d; cs_dev_n = c0; cs_rank_n = c1;
    if (!(c0 && c1)) model_word = d;
    @(posedge clk);
    #1;
    exp_q.push_back(image(dup_mode, alt_map, model_word));
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(posedge clk);
    #2;
  endtask

  // reset with new config, then release and check the synchroniser (R7, R8)
  task automatic restart(input logic dup, input logic alt);
    drain();
    rst_n = 1'b0;
    #1;
    check("R7 async clear", cmd_q, '0);
    dup_mode = dup; alt_map = alt; model_word = '0;
    cmd_d = '1; cs_dev_n = 1'b0; cs_rank_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 held in reset", cmd_q, '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 edge1 idle", cmd_q, '0);
    @(posedge clk); @(negedge clk);
    check("R8 edge2 idle", cmd_q, '0);
    @(posedge clk); @(negedge clk);
    model_word = '1;
    check("R8 edge3 capture", cmd_q, image(dup, alt, '1));
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R7 reset state", cmd_q, '0);

    // wide mode
    restart(1'b0, 1'b0);
    step(25'h1A5_5A5A, 1'b0, 1'b1, "R1 wide");
    step(25'h0F0_F0F0, 1'b1, 1'b0, "R1 wide");
    step(25'h155_5555, 1'b0, 1'b0, "R6 either low");
    step(25'h0AA_AAAA, 1'b1, 1'b1, "R5 freeze");
    step(25'h000_0001, 1'b1, 1'b1, "R5 freeze");
    step(25'h100_0000, 1'b0, 1'b1, "R6 reopen");
    for (int k = 0; k < 20; k++)
      step(25'(k * 32'h0049_1F3B + 32'h0123_4567), 1'(k % 3 == 0), 1'(k % 2),
           "R1 sweep");

    // R4: change between edges does not reach output
    drain();
    @(negedge clk);
    cmd_d = 25'h0C3_3C3C;
    #2;
    check("R4 no mid-cycle change", cmd_q, last_seen);
    cmd_d = 25'h13C_C3C3;
    #1;
    check("R4 no mid-cycle change", cmd_q, last_seen);

    // duplicated, arrangement A; upper bits vary and must not matter
    restart(1'b1, 1'b0);
    step(25'h1FF_C000, 1'b0, 1'b0, "R2 upper ignored");
    step(25'h000_2AAB, 1'b0, 1'b0, "R2 dup A");
    step(25'h155_1234, 1'b1, 1'b0, "R2 dup A");
    step(25'h0AB_0001, 1'b1, 1'b1, "R5 freeze dup A");
    for (int k = 0; k < 16; k++)
      step(25'(k * 32'h0151_7A29 + 32'h0000_0F0F), 1'b0, 1'(k % 2), "R2 sweep");

    // duplicated, arrangement B
    restart(1'b1, 1'b1);
    step(25'h000_0001, 1'b0, 1'b0, "R3 dup B");
    step(25'h000_2000, 1'b0, 1'b0, "R3 dup B");
    step(25'h1C0_1234, 1'b0, 1'b1, "R3 dup B");
    step(25'h000_3FFF, 1'b1, 1'b1, "R5 freeze dup B");
    for (int k = 0; k < 16; k++)
      step(25'(k * 32'h00A3_0C71 + 32'h0000_1357), 1'(k % 2), 1'b0, "R3 sweep");

    // R9: reset wins over an active freeze
    step(25'h000_1555, 1'b0, 1'b0, "R3 dup B");
    step(25'h000_0AAA, 1'b1, 1'b1, "R9 frozen");
    drain();
    check("R9 frozen nonzero", cmd_q, image(1'b1, 1'b1, 25'h000_1555));
    rst_n = 1'b0;
    #1;
    check("R9 reset beats freeze", cmd_q, '0);
    @(negedge clk);
    check("R9 reset beats freeze", cmd_q, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule